// File: doc/BRIEF.md
# Two-by-Two Displacement Solver

This block turns the spatially averaged structure tensor of one pixel into a displacement vector. Each transaction carries the three distinct entries of a symmetric 2x2 matrix G (top-left `g1`, off-diagonal `g2`, bottom-right `g4`) and a two-entry right-hand vector h. The block returns d = G⁻¹·h as two signed fixed-point components, `dx` and `dy`.

G is never inverted. The block forms the adjugate-times-vector product and the determinant side by side, both in exact integer arithmetic. It then divides each product component by the determinant. The divisions use two sequential restoring dividers that run in lockstep and produce `FRAC` fractional bits. A pixel whose determinant is zero gives a zero vector and has its `out_singular` flag raised.

Both edges of the block use a valid/ready handshake. Only one pixel is in flight at any time, so results leave in the order they were accepted.

Top module: `disp2_solver`

## Requirements
- R1: The unscaled numerators are nx = g4·h1 − g2·h2 and ny = g1·h2 − g2·h1. They are computed exactly, with no rounding.
- R2: The determinant is det = g1·g4 − g2². The reported component is trunc(n·2^FRAC / det), rounded toward zero.
- R3: `out_dx` and `out_dy` are two's complement values with FRAC fractional bits (default FRAC = 8). A value of 256 means one pixel.
- R4: A quotient outside [−2^(OUT_W−1), 2^(OUT_W−1)−1] is clamped to the nearer bound.
- R5: When det = 0, both outputs are 0 and `out_singular` is 1. Otherwise `out_singular` is 0.
- R6: After reset, `in_ready` is 1. It drops on the cycle after a pixel is accepted and returns to 1 only after that pixel's result has been taken.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_dx`, `out_dy` and `out_singular` hold their values.
- R8: During reset `out_valid` is 0. Results come out in the order the pixels were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Pixel tensor present |
| in_ready | output | 1 | Block can take a pixel |
| in_g1 | input | IN_W | G top-left entry, signed |
| in_g2 | input | IN_W | G off-diagonal entry, signed |
| in_g4 | input | IN_W | G bottom-right entry, signed |
| in_h1 | input | IN_W | h first entry, signed |
| in_h2 | input | IN_W | h second entry, signed |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_dx | output | OUT_W | Horizontal displacement, signed, FRAC fractional bits |
| out_dy | output | OUT_W | Vertical displacement, signed, FRAC fractional bits |
| out_singular | output | 1 | Determinant was zero for this pixel |

## Verification
The assertions take two things for granted.
- The consumer keeps `out_ready` meaningful only while `out_valid` is high.
- The producer never sees a second acceptance before the first result has drained.

The bench meets both conditions by construction: it raises `in_valid` for exactly one pixel at a time and pulses `out_ready` once per result. The inputs may use the full signed IN_W range, because the internal width 2·IN_W+1 holds every numerator and determinant. The random stimulus therefore mixes well-conditioned tensors with full-range values that drive the clamp. Directed cases add exact singular matrices and the most negative input codes.

// File: rtl/dsolve_pkg.sv
package dsolve_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_DIV  = 2'd2,
    ST_OUT  = 2'd3
  } solve_st_e;
endpackage

// File: rtl/dsolve_adj.sv
// Exact adjugate-times-vector product and determinant, computed in parallel.
module dsolve_adj #(
  parameter int IN_W  = 16,
  parameter int NUM_W = 2 * IN_W + 1
) (
  input  logic signed [IN_W-1:0]  g1,
  input  logic signed [IN_W-1:0]  g2,
  input  logic signed [IN_W-1:0]  g4,
  input  logic signed [IN_W-1:0]  h1,
  input  logic signed [IN_W-1:0]  h2,
  output logic signed [NUM_W-1:0] num_x,
  output logic signed [NUM_W-1:0] num_y,
  output logic signed [NUM_W-1:0] det
);
  function automatic logic signed [NUM_W-1:0] smul(input logic signed [IN_W-1:0] a,
                                                   input logic signed [IN_W-1:0] b);
    logic signed [NUM_W-1:0] ea;
    logic signed [NUM_W-1:0] eb;
    ea = a;
    eb = b;
    return ea * eb;
  endfunction

  // R1: numerators from the adjugate [[g4,-g2],[-g2,g1]] times h
  always_comb begin
    num_x = smul(g4, h1) - smul(g2, h2);
    num_y = smul(g1, h2) - smul(g2, h1);
  end

  // R2: determinant, independent of the product path
  always_comb det = smul(g1, g4) - smul(g2, g2);
endmodule

// File: rtl/dsolve_div.sv
// Sequential restoring divider on magnitudes, sign fixed and clamped at the end.
module dsolve_div #(
  parameter int NUM_W = 33,
  parameter int FRAC  = 8,
  parameter int OUT_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic signed [NUM_W-1:0] num,
  input  logic signed [NUM_W-1:0] den,
  output logic                    busy,
  output logic                    done,
  output logic signed [OUT_W-1:0] quo
);
  localparam int DVD_W = NUM_W + FRAC;
  localparam int CNT_W = $clog2(DVD_W + 1);
  localparam logic [DVD_W-1:0] Q_POS_MAX = DVD_W'((64'd1 << (OUT_W - 1)) - 64'd1);
  localparam logic [DVD_W-1:0] Q_NEG_MAX = DVD_W'(64'd1 << (OUT_W - 1));

  function automatic logic [NUM_W-1:0] mag(input logic signed [NUM_W-1:0] v);
    return v[NUM_W-1] ? NUM_W'(-v) : NUM_W'(v);
  endfunction

  // R4: clamp magnitude and apply sign
  function automatic logic signed [OUT_W-1:0] sat_sign(input logic [DVD_W-1:0] q,
                                                        input logic neg);
    logic [DVD_W-1:0] lim;
    lim = neg ? Q_NEG_MAX : Q_POS_MAX;
    if (q > lim) q = lim;
    return neg ? OUT_W'(-q) : OUT_W'(q);
  endfunction

  logic [DVD_W-1:0] dvd_q;
  logic [DVD_W-1:0] quot_q;
  logic [NUM_W-1:0] rem_q;
  logic [NUM_W-1:0] dmag_q;
  logic             neg_q;
  logic [CNT_W-1:0] cnt_q;

  logic [NUM_W:0]   trial;
  logic             take;
  logic [NUM_W-1:0] rem_next;
  logic [DVD_W-1:0] quot_next;
  logic             last_step;

  always_comb begin
    trial     = {rem_q, dvd_q[DVD_W-1]};
    take      = trial >= {1'b0, dmag_q};
    rem_next  = take ? NUM_W'(trial - {1'b0, dmag_q}) : NUM_W'(trial);
    quot_next = {quot_q[DVD_W-2:0], take};
    last_step = busy && (cnt_q == CNT_W'(DVD_W - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      quo    <= '0;
      dvd_q  <= '0;
      quot_q <= '0;
      rem_q  <= '0;
      dmag_q <= '0;
      neg_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy   <= 1'b1;
        dvd_q  <= {mag(num), {FRAC{1'b0}}};
        dmag_q <= mag(den);
        neg_q  <= num[NUM_W-1] ^ den[NUM_W-1];
        rem_q  <= '0;
        quot_q <= '0;
        cnt_q  <= '0;
      end else if (busy) begin
        rem_q  <= rem_next;
        quot_q <= quot_next;
        dvd_q  <= {dvd_q[DVD_W-2:0], 1'b0};
        cnt_q  <= cnt_q + 1'b1;
        if (last_step) begin
          busy <= 1'b0;
          done <= 1'b1;
          quo  <= sat_sign(quot_next, neg_q);
        end
      end
    end
  end

  // R6: the controller never restarts a running division
  p_no_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start);
  // R2: a start always leads into a running division
  p_start_runs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
  // R2: completion marks the end of a division
  p_done_ends_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

// File: rtl/disp2_solver.sv
module disp2_solver #(
  parameter int IN_W  = 16,
  parameter int OUT_W = 16,
  parameter int FRAC  = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic signed [IN_W-1:0] in_g1,
  input  logic signed [IN_W-1:0] in_g2,
  input  logic signed [IN_W-1:0] in_g4,
  input  logic signed [IN_W-1:0] in_h1,
  input  logic signed [IN_W-1:0] in_h2,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic signed [OUT_W-1:0] out_dx,
  output logic signed [OUT_W-1:0] out_dy,
  output logic                   out_singular
);
  import dsolve_pkg::*;

  localparam int NUM_W = 2 * IN_W + 1;
  localparam int N_CMP = 2;

  solve_st_e st_q;
  logic signed [IN_W-1:0] g1_q, g2_q, g4_q, h1_q, h2_q;

  logic signed [NUM_W-1:0] num_x, num_y, det;
  logic signed [NUM_W-1:0] num_arr [N_CMP];
  logic signed [OUT_W-1:0] quo_arr [N_CMP];
  logic [N_CMP-1:0] div_busy;
  logic [N_CMP-1:0] div_done;

  // named events for the assertions
  logic acc_fire;
  logic out_fire;
  logic det_zero;
  logic div_start;
  logic div_finish;

  assign in_ready   = (st_q == ST_IDLE);
  assign out_valid  = (st_q == ST_OUT);
  assign acc_fire   = in_valid && in_ready;
  assign out_fire   = out_valid && out_ready;
  assign det_zero   = (det == '0);
  assign div_start  = (st_q == ST_LOAD) && !det_zero;
  assign div_finish = (st_q == ST_DIV) && (&div_done);

  dsolve_adj #(.IN_W(IN_W), .NUM_W(NUM_W)) u_adj (
    .g1(g1_q), .g2(g2_q), .g4(g4_q), .h1(h1_q), .h2(h2_q),
    .num_x(num_x), .num_y(num_y), .det(det)
  );

  assign num_arr[0] = num_x;
  assign num_arr[1] = num_y;

  for (genvar k = 0; k < N_CMP; k++) begin : g_div
    dsolve_div #(.NUM_W(NUM_W), .FRAC(FRAC), .OUT_W(OUT_W)) u_div (
      .clk(clk), .rst_n(rst_n), .start(div_start),
      .num(num_arr[k]), .den(det),
      .busy(div_busy[k]), .done(div_done[k]), .quo(quo_arr[k])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q         <= ST_IDLE;
      g1_q         <= '0;
      g2_q         <= '0;
      g4_q         <= '0;
      h1_q         <= '0;
      h2_q         <= '0;
      out_dx       <= '0;
      out_dy       <= '0;
      out_singular <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (acc_fire) begin
          g1_q <= in_g1;
          g2_q <= in_g2;
          g4_q <= in_g4;
          h1_q <= in_h1;
          h2_q <= in_h2;
          st_q <= ST_LOAD;
        end
        ST_LOAD: if (det_zero) begin
          out_dx       <= '0;
          out_dy       <= '0;
          out_singular <= 1'b1;
          st_q         <= ST_OUT;
        end else begin
          st_q <= ST_DIV;
        end
        ST_DIV: if (div_finish) begin
          out_dx       <= quo_arr[0];
          out_dy       <= quo_arr[1];
          out_singular <= 1'b0;
          st_q         <= ST_OUT;
        end
        ST_OUT: if (out_fire) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R6: one pixel in flight
  p_one_in_flight_r6: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fire |=> !in_ready);
  p_no_accept_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|div_busy) |-> !in_ready);
  // R7: held result under back-pressure
  p_out_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_dx) && $stable(out_dy)
                                && $stable(out_singular));
  // R5: a singular result carries a zero vector
  p_singular_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_singular |-> out_dx == '0 && out_dy == '0);
  // R2: both dividers run in lockstep
  p_div_lockstep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    div_done[0] == div_done[1]);
  // R8: a result appears only after a pixel went in
  p_out_after_in_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> !in_ready);
endmodule

// File: tb/test_disp2_solver.sv
module test_disp2_solver;
  localparam int IN_W  = 16;
  localparam int OUT_W = 16;
  localparam int FRAC  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic signed [IN_W-1:0] in_g1 = '0, in_g2 = '0, in_g4 = '0, in_h1 = '0, in_h2 = '0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic signed [OUT_W-1:0] out_dx, out_dy;
  logic out_singular;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  disp2_solver #(.IN_W(IN_W), .OUT_W(OUT_W), .FRAC(FRAC)) i_disp2_solver (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_g1(in_g1), .in_g2(in_g2), .in_g4(in_g4), .in_h1(in_h1), .in_h2(in_h2),
    .out_valid(out_valid), .out_ready(out_ready), .out_dx(out_dx), .out_dy(out_dy),
    .out_singular(out_singular)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R2/R3/R4 model: truncating division toward zero, then clamp
  function automatic longint model_q(input longint n, input longint d);
    longint q;
    longint hi = (longint'(1) << (OUT_W - 1)) - 1;
    longint lo = -(longint'(1) << (OUT_W - 1));
    if (d == 0) return 0;
    q = (n * (longint'(1) << FRAC)) / d;
    if (q > hi) q = hi;
    if (q < lo) q = lo;
    return q;
  endfunction

  function automatic bit will_clamp(input longint n, input longint d);
    longint q;
    if (d == 0) return 1'b0;
    q = (n * (longint'(1) << FRAC)) / d;
    return (q > 32767) || (q < -32768);
  endfunction

  task automatic run_one(input longint a1, input longint a2, input longint a4,
                         input longint b1, input longint b2, input int stall);
    longint dt, nx, ny, ex, ey;
    logic signed [OUT_W-1:0] hx, hy;
    logic hs;
    int n;
    dt = a1 * a4 - a2 * a2;
    nx = a4 * b1 - a2 * b2;
    ny = a1 * b2 - a2 * b1;
    ex = model_q(nx, dt);
    ey = model_q(ny, dt);
    @(negedge clk);
    in_g1 = IN_W'(a1); in_g2 = IN_W'(a2); in_g4 = IN_W'(a4);
    in_h1 = IN_W'(b1); in_h2 = IN_W'(b2);
    in_valid = 1'b1;
    n = 0;
    while (!in_ready && n < 1000) begin @(negedge clk); n++; end
    @(negedge clk);
    in_valid = 1'b0;
    chk(in_ready == 1'b0, "R6 in_ready after accept", longint'(in_ready), 0);
    n = 0;
    while (!out_valid && n < 1000) begin @(negedge clk); n++; end
    if (!out_valid) begin
      chk(1'b0, "R8 result timeout", 0, 1);
      return;
    end
    chk(longint'(out_dx) == ex, will_clamp(nx, dt) ? "R4 dx clamp" : "R1/R2/R3 dx",
        longint'(out_dx), ex);
    chk(longint'(out_dy) == ey, will_clamp(ny, dt) ? "R4 dy clamp" : "R1/R2/R3 dy",
        longint'(out_dy), ey);
    chk(out_singular == (dt == 0), "R5 singular flag", longint'(out_singular),
        longint'(dt == 0));
    hx = out_dx; hy = out_dy; hs = out_singular;
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      chk(out_valid && out_dx == hx && out_dy == hy && out_singular == hs,
          "R7 hold under stall", longint'(out_dx), longint'(hx));
    end
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk(!out_valid && in_ready, "R6 ready after drain", longint'(in_ready), 1);
  endtask

  function automatic longint rnd_s(input int span);
    return longint'($urandom_range(2 * span, 0)) - span;
  endfunction

  initial begin
    void'($urandom(32'd20250611));
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R8 reset out_valid", longint'(out_valid), 0);
    chk(in_ready == 1'b1, "R6 reset in_ready", longint'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R6 idle in_ready", longint'(in_ready), 1);

    // directed: identity-scaled, known answer 512 / -256 (R3)
    run_one(256, 0, 256, 512, -256, 2);
    // off-diagonal coupling
    run_one(300, 100, 200, 1000, -700, 0);
    // singular: det = 100*100 - 100*100 (R5)
    run_one(100, 100, 100, 400, -900, 3);
    // all-zero tensor (R5)
    run_one(0, 0, 0, 0, 0, 1);
    // clamp both ways (R4)
    run_one(1, 0, 1, 30000, -30000, 1);
    // most negative codes
    run_one(-32768, -32768, -32768, -32768, 32767, 0);
    run_one(-32768, 0, 32767, 32767, -32768, 2);
    // negative determinant
    run_one(10, 50, 10, 77, -13, 0);

    for (int i = 0; i < 60; i++) begin
      if (i % 3 == 0)
        run_one(rnd_s(32768) % 32768, rnd_s(32768) % 32768, rnd_s(32768) % 32768,
                rnd_s(32768) % 32768, rnd_s(32768) % 32768, $urandom_range(3, 0));
      else
        run_one(longint'($urandom_range(4000, 500)), rnd_s(400),
                longint'($urandom_range(4000, 500)), rnd_s(3000), rnd_s(3000),
                $urandom_range(3, 0));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule